// File: doc/BRIEF.md
# Receive Frame Timing Marker Generator

This block produces the framing strobes that go with a receive system highway clocked at one bit per clock, in either E1 (256-bit frames) or T1 (193-bit frames) operation. A synchronization pulse taken from one of several multifunction ports, together with a programmable bit offset, fixes where time slot 0 begins. From that point the block keeps a bit-position counter and a frame counter, and it derives three strobes from them: a frame marker at a programmable bit position, a multiframe-begin marker, and a signaling marker that follows a per-time-slot mask or, in T1 robbed-bit operation, the robbed bits.

Each multifunction port carries a 4-bit function code. The code makes the port either the synchronization input or a driver of one of the three strobes. A configuration bit selects whether the strobes change on the rising or the falling clock edge. All configuration inputs are static levels, expected to be held by surrounding register logic.

Top module: `rx_frame_marker`

## Requirements
- R1: While `rst_ni` is low, every port output is 0, and the counters restart at bit position 0 of frame 0.
- R2: The sync input is the lowest-numbered port whose function code is 0000. The input pins of every other port are ignored. Because codes default to 0000, port 0 is the sync source out of reset.
- R3: A sync input sampled high at a rising edge loads the bit position with the offset and the frame counter with 0. An offset not below the current frame length loads position 0.
- R4: The bit position counts 0 to 255 in E1 and 0 to 192 in T1, then wraps. At each wrap the frame counter advances modulo 16 (E1), 12 (T1 superframe, `esf_i`=0) or 24 (T1 extended, `esf_i`=1).
- R5: The frame marker is high for one bit period per frame, at bit position `fm_pos_i`.
- R6: In E1 the multiframe marker is high at position 0 of frame 0. With `cas_mf_i`=1 it is high instead at position 128, the first bit of time slot 16, of frame 0.
- R7: In T1 with `mf_sel_i`=1 the multiframe marker is high at position 0 of frame 0. With `mf_sel_i`=0 it is high at position 0 of every frame whose number is a multiple of 12.
- R8: Without robbed-bit marking, the signaling marker is high on every bit of a slot whose mask bit is set. The slot is position/8 in E1. In T1 it is (position-1)/8, and position 0, the framing bit, is never marked.
- R9: In T1 with `rbs_en_i`=1, the signaling marker is high only at positions 8, 16, …, 192 of frames 5, 11, 17 and 23, numbered from 0.
- R10: Codes 0001, 0010 and 0011 drive the frame marker, the multiframe marker and the signaling marker onto the port, with its output enable high. Any other code holds the output and its enable low.
- R11: Each marker reflects the counter state of the previous cycle. With `fall_edge_i`=0 it changes at the rising edge; with `fall_edge_i`=1 it changes at the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t1_mode_i | input | 1 | 1 = T1 frame, 0 = E1 frame |
| esf_i | input | 1 | T1 24-frame multiframe when 1 |
| mf_sel_i | input | 1 | T1 multiframe (1) or 12-frame (0) marking |
| cas_mf_i | input | 1 | E1 marks CAS multiframe start |
| rbs_en_i | input | 1 | T1 robbed-bit signaling marking |
| fall_edge_i | input | 1 | Markers change on falling edge |
| sync_off_i | input | 8 | Bit position loaded on sync |
| fm_pos_i | input | 8 | Frame marker bit position |
| slot_mask_i | input | 32 | Per-time-slot signaling mask |
| port_func_i | input | 16 | 4-bit function code per port, port 0 in bits 3:0 |
| port_i | input | 4 | Port input pins |
| port_o | output | 4 | Port output values |
| port_oe_o | output | 4 | Port output enables |

## Verification
A sync input sampled at a rising edge moves the counters at that edge. The markers for that counter state appear one clock later: at the next rising edge in rising mode, or half a clock after it in falling mode. The bench keeps its own arithmetic model of position and frame, advances it at each rising edge, and derives the expected markers from the state before the update. It samples a quarter period after the rising edge, where falling mode must still show the previous cycle's markers and rising mode the new ones, and again three quarters in, where both modes show the new ones. Frame lengths are measured as the spacing between successive frame-marker pulses at the port.

// File: rtl/rfm_pkg.sv
`timescale 1ns/1ps
package rfm_pkg;
  localparam int FUNC_W = 4;

  typedef enum logic [FUNC_W-1:0] {
    FN_SYNC  = 4'h0,
    FN_FRAME = 4'h1,
    FN_MFB   = 4'h2,
    FN_SIG   = 4'h3
  } port_fn_e;

  typedef struct packed {
    logic fm;
    logic mfb;
    logic sig;
  } marks_t;
endpackage

// File: rtl/rfm_sync_sel.sv
`timescale 1ns/1ps
module rfm_sync_sel
  import rfm_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic [N_PORTS*FUNC_W-1:0] port_func_i,
  input  logic [N_PORTS-1:0]        port_i,
  output logic                      sync_o
);
  // scan downward so the lowest sync-coded port wins
  always_comb begin
    sync_o = 1'b0;
    for (int i = N_PORTS-1; i >= 0; i--) begin
      if (port_func_i[i*FUNC_W +: FUNC_W] == FN_SYNC) sync_o = port_i[i];
    end
  end
endmodule

// File: rtl/rfm_counter.sv
`timescale 1ns/1ps
module rfm_counter #(
  parameter int E1_BITS = 256,
  parameter int T1_BITS = 193,
  parameter int E1_MF   = 16,
  parameter int T1_SF   = 12,
  parameter int T1_ESF  = 24,
  parameter int POS_W   = 8,
  parameter int FRM_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             t1_mode_i,
  input  logic             esf_i,
  input  logic             sync_i,
  input  logic [POS_W-1:0] sync_off_i,
  output logic [POS_W-1:0] pos_o,
  output logic [FRM_W-1:0] frame_o
);
  localparam logic [POS_W:0]   E1_LEN = (POS_W+1)'(E1_BITS);
  localparam logic [POS_W:0]   T1_LEN = (POS_W+1)'(T1_BITS);
  localparam logic [FRM_W-1:0] E1_MFL = FRM_W'(E1_MF);
  localparam logic [FRM_W-1:0] SF_MFL = FRM_W'(T1_SF);
  localparam logic [FRM_W-1:0] ES_MFL = FRM_W'(T1_ESF);

  logic [POS_W:0]   len;
  logic [FRM_W-1:0] mf_len;
  logic             pos_wrap;
  logic             frm_wrap;

  assign len      = t1_mode_i ? T1_LEN : E1_LEN;
  assign mf_len   = !t1_mode_i ? E1_MFL : (esf_i ? ES_MFL : SF_MFL);
  // >= rather than == so a mode switch never strands the counter
  assign pos_wrap = {1'b0, pos_o} >= (len - 1'b1);
  assign frm_wrap = frame_o >= (mf_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o   <= '0;
      frame_o <= '0;
    end else if (sync_i) begin
      pos_o   <= ({1'b0, sync_off_i} < len) ? sync_off_i : '0;
      frame_o <= '0;
    end else if (pos_wrap) begin
      pos_o   <= '0;
      frame_o <= frm_wrap ? '0 : frame_o + 1'b1;
    end else begin
      pos_o   <= pos_o + 1'b1;
    end
  end
endmodule

// File: rtl/rfm_marker.sv
`timescale 1ns/1ps
module rfm_marker
  import rfm_pkg::*;
#(
  parameter int POS_W      = 8,
  parameter int FRM_W      = 5,
  parameter int MASK_W     = 32,
  parameter int SLOT_BITS  = 8,
  parameter int CAS_SLOT   = 16,
  parameter int T1_SF      = 12,
  parameter int RBS_PERIOD = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              t1_mode_i,
  input  logic              mf_sel_i,
  input  logic              cas_mf_i,
  input  logic              rbs_en_i,
  input  logic [POS_W-1:0]  fm_pos_i,
  input  logic [MASK_W-1:0] slot_mask_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [FRM_W-1:0]  frame_i,
  output marks_t            mk_o
);
  localparam int SLOT_W  = $clog2(MASK_W);
  localparam int CAS_POS = CAS_SLOT * SLOT_BITS;

  logic [31:0]       pos_w;
  logic [31:0]       frm_w;
  logic [SLOT_W-1:0] slot;
  logic              pos_zero;
  logic              frm_zero;
  logic              rb_frame;
  logic              rb_bit;
  marks_t            mk_d;

  assign pos_w    = 32'(pos_i);
  assign frm_w    = 32'(frame_i);
  assign pos_zero = (pos_i == '0);
  assign frm_zero = (frame_i == '0);
  // T1 slot numbering skips the framing bit at position 0
  assign slot     = SLOT_W'((t1_mode_i ? pos_w - 32'd1 : pos_w) / 32'(SLOT_BITS));
  assign rb_frame = (frm_w % 32'(RBS_PERIOD)) == 32'(RBS_PERIOD - 1);
  assign rb_bit   = !pos_zero && ((pos_w % 32'(SLOT_BITS)) == 32'd0);

  always_comb begin
    mk_d.fm = (pos_i == fm_pos_i);
    if (t1_mode_i) begin
      mk_d.mfb = pos_zero && (mf_sel_i ? frm_zero
                                       : ((frm_w % 32'(T1_SF)) == 32'd0));
    end else if (cas_mf_i) begin
      mk_d.mfb = frm_zero && (pos_w == 32'(CAS_POS));
    end else begin
      mk_d.mfb = frm_zero && pos_zero;
    end
    if (t1_mode_i && rbs_en_i)  mk_d.sig = rb_bit && rb_frame;
    else if (t1_mode_i)         mk_d.sig = !pos_zero && slot_mask_i[slot];
    else                        mk_d.sig = slot_mask_i[slot];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mk_o <= '0;
    else         mk_o <= mk_d;
  end
endmodule

// File: rtl/rfm_port_mux.sv
`timescale 1ns/1ps
module rfm_port_mux
  import rfm_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fall_edge_i,
  input  marks_t                    mk_i,
  input  logic [N_PORTS*FUNC_W-1:0] port_func_i,
  output logic [N_PORTS-1:0]        port_o,
  output logic [N_PORTS-1:0]        port_oe_o
);
  marks_t mk_neg;
  marks_t mk_sel;

  // half-cycle retime for falling-edge launch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mk_neg <= '0;
    else         mk_neg <= mk_i;
  end

  assign mk_sel = fall_edge_i ? mk_neg : mk_i;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic [FUNC_W-1:0] fn;
    logic              val;
    logic              en;

    assign fn = port_func_i[g*FUNC_W +: FUNC_W];

    always_comb begin
      val = 1'b0;
      en  = 1'b0;
      case (fn)
        FN_FRAME: begin val = mk_sel.fm;  en = 1'b1; end
        FN_MFB:   begin val = mk_sel.mfb; en = 1'b1; end
        FN_SIG:   begin val = mk_sel.sig; en = 1'b1; end
        default:  begin val = 1'b0;       en = 1'b0; end
      endcase
    end

    assign port_o[g]    = val;
    assign port_oe_o[g] = en;
  end
endmodule

// File: rtl/rx_frame_marker.sv
`timescale 1ns/1ps
module rx_frame_marker
  import rfm_pkg::*;
#(
  parameter int N_PORTS    = 4,
  parameter int E1_BITS    = 256,
  parameter int T1_BITS    = 193,
  parameter int SLOT_BITS  = 8,
  parameter int MASK_W     = 32,
  parameter int E1_MF      = 16,
  parameter int T1_SF      = 12,
  parameter int T1_ESF     = 24,
  parameter int RBS_PERIOD = 6,
  parameter int CAS_SLOT   = 16,
  localparam int POS_W     = $clog2(E1_BITS),
  localparam int FRM_W     = $clog2((E1_MF > T1_ESF) ? E1_MF : T1_ESF)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      t1_mode_i,
  input  logic                      esf_i,
  input  logic                      mf_sel_i,
  input  logic                      cas_mf_i,
  input  logic                      rbs_en_i,
  input  logic                      fall_edge_i,
  input  logic [POS_W-1:0]          sync_off_i,
  input  logic [POS_W-1:0]          fm_pos_i,
  input  logic [MASK_W-1:0]         slot_mask_i,
  input  logic [N_PORTS*FUNC_W-1:0] port_func_i,
  input  logic [N_PORTS-1:0]        port_i,
  output logic [N_PORTS-1:0]        port_o,
  output logic [N_PORTS-1:0]        port_oe_o
);
  logic             sync;
  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frame_q;
  marks_t           mk;

  rfm_sync_sel #(.N_PORTS(N_PORTS)) u_sync_sel (
    .port_func_i (port_func_i),
    .port_i      (port_i),
    .sync_o      (sync)
  );

  rfm_counter #(
    .E1_BITS (E1_BITS),
    .T1_BITS (T1_BITS),
    .E1_MF   (E1_MF),
    .T1_SF   (T1_SF),
    .T1_ESF  (T1_ESF),
    .POS_W   (POS_W),
    .FRM_W   (FRM_W)
  ) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .t1_mode_i  (t1_mode_i),
    .esf_i      (esf_i),
    .sync_i     (sync),
    .sync_off_i (sync_off_i),
    .pos_o      (pos_q),
    .frame_o    (frame_q)
  );

  rfm_marker #(
    .POS_W      (POS_W),
    .FRM_W      (FRM_W),
    .MASK_W     (MASK_W),
    .SLOT_BITS  (SLOT_BITS),
    .CAS_SLOT   (CAS_SLOT),
    .T1_SF      (T1_SF),
    .RBS_PERIOD (RBS_PERIOD)
  ) u_marker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .t1_mode_i   (t1_mode_i),
    .mf_sel_i    (mf_sel_i),
    .cas_mf_i    (cas_mf_i),
    .rbs_en_i    (rbs_en_i),
    .fm_pos_i    (fm_pos_i),
    .slot_mask_i (slot_mask_i),
    .pos_i       (pos_q),
    .frame_i     (frame_q),
    .mk_o        (mk)
  );

  rfm_port_mux #(.N_PORTS(N_PORTS)) u_port_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_edge_i (fall_edge_i),
    .mk_i        (mk),
    .port_func_i (port_func_i),
    .port_o      (port_o),
    .port_oe_o   (port_oe_o)
  );
endmodule

// File: rtl/rx_frame_marker_chk.sv
`timescale 1ns/1ps
module rx_frame_marker_chk
  import rfm_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int E1_BITS   = 256,
  parameter int T1_BITS   = 193,
  parameter int SLOT_BITS = 8,
  parameter int POS_W     = 8,
  parameter int FRM_W     = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               t1_mode_i,
  input logic               cas_mf_i,
  input logic               rbs_en_i,
  input logic [POS_W-1:0]   sync_off_i,
  input logic [POS_W-1:0]   fm_pos_i,
  input logic [N_PORTS-1:0] port_o,
  input logic [N_PORTS-1:0] port_oe_o,
  input logic               sync_i,
  input logic [POS_W-1:0]   pos_i,
  input logic [FRM_W-1:0]   frame_i,
  input marks_t             mk_i
);
  localparam logic [POS_W:0] E1_LEN = (POS_W+1)'(E1_BITS);
  localparam logic [POS_W:0] T1_LEN = (POS_W+1)'(T1_BITS);

  logic [POS_W:0] len;
  assign len = t1_mode_i ? T1_LEN : E1_LEN;

  AST_POS_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(t1_mode_i) |-> ({1'b0, pos_i} < len)); // R4

  AST_SYNC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && ({1'b0, sync_off_i} < len))
      |=> (pos_i == $past(sync_off_i)) && (frame_i == '0)); // R3

  AST_FM_SINGLE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mk_i.fm && !$past(sync_i) && $stable(fm_pos_i)) |=> !mk_i.fm); // R5

  AST_E1_MFB_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mk_i.mfb && $past(!t1_mode_i && !cas_mf_i))
      |-> ($past(frame_i) == '0) && ($past(pos_i) == '0)); // R6

  AST_RBS_BIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mk_i.sig && $past(t1_mode_i && rbs_en_i))
      |-> ((32'($past(pos_i)) % 32'(SLOT_BITS)) == 32'd0)); // R9

  AST_OUT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_o & ~port_oe_o) == '0); // R10
endmodule

bind rx_frame_marker rx_frame_marker_chk #(
  .N_PORTS   (N_PORTS),
  .E1_BITS   (E1_BITS),
  .T1_BITS   (T1_BITS),
  .SLOT_BITS (SLOT_BITS),
  .POS_W     (POS_W),
  .FRM_W     (FRM_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .t1_mode_i  (t1_mode_i),
  .cas_mf_i   (cas_mf_i),
  .rbs_en_i   (rbs_en_i),
  .sync_off_i (sync_off_i),
  .fm_pos_i   (fm_pos_i),
  .port_o     (port_o),
  .port_oe_o  (port_oe_o),
  .sync_i     (sync),
  .pos_i      (pos_q),
  .frame_i    (frame_q),
  .mk_i       (mk)
);

// File: tb/rx_frame_marker_bench.sv
`timescale 1ns/1ps
module rx_frame_marker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        t1 = 1'b0, esf = 1'b0, mf_sel = 1'b0, cas = 1'b0, rbs = 1'b0, fall = 1'b0;
  logic [7:0]  off = '0, fmp = '0;
  logic [31:0] mask = '0;
  logic [15:0] func = '0;
  logic [3:0]  pin = '0;
  logic [3:0]  pout, poe;

  rx_frame_marker u_rx_frame_marker (
    .clk_i(clk), .rst_ni(rst_n), .t1_mode_i(t1), .esf_i(esf), .mf_sel_i(mf_sel),
    .cas_mf_i(cas), .rbs_en_i(rbs), .fall_edge_i(fall), .sync_off_i(off),
    .fm_pos_i(fmp), .slot_mask_i(mask), .port_func_i(func), .port_i(pin),
    .port_o(pout), .port_oe_o(poe)
  );

  always #10 clk = ~clk;

  int    checks = 0, errors = 0;
  int    m_pos = 0, m_frame = 0;
  bit    c_fm = 0, c_mfb = 0, c_sig = 0, p_fm = 0, p_mfb = 0, p_sig = 0;
  string tag = "";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flen();
    return t1 ? 193 : 256;
  endfunction

  function automatic int mflen();
    return !t1 ? 16 : (esf ? 24 : 12);
  endfunction

  function automatic bit f_mfb(int p, int f);
    if (!t1) return cas ? (f == 0 && p == 128) : (f == 0 && p == 0);
    return p == 0 && (mf_sel ? f == 0 : (f % 12) == 0);
  endfunction

  function automatic bit f_sig(int p, int f);
    if (t1 && rbs) return p != 0 && (p % 8) == 0 && (f % 6) == 5;
    if (t1) return p != 0 && mask[(p - 1) / 8];
    return mask[p / 8];
  endfunction

  function automatic int sync_src();
    for (int i = 0; i < 4; i++) if (func[i*4 +: 4] == 4'h0) return i;
    return -1;
  endfunction

  task automatic cmp_ports(bit fm, bit mfb, bit sig, string over);
    for (int i = 0; i < 4; i++) begin
      int    code;
      bit    eo, ee;
      string req;
      code = int'(func[i*4 +: 4]);
      eo = (code == 1) ? fm : (code == 2) ? mfb : (code == 3) ? sig : 1'b0;
      ee = (code >= 1 && code <= 3);
      if (over != "")     req = over;
      else if (tag != "") req = tag;
      else if (code == 1) req = "R5";
      else if (code == 2) req = t1 ? "R7" : "R6";
      else if (code == 3) req = (t1 && rbs) ? "R9" : "R8";
      else                req = "R10";
      chk(req, int'(pout[i]), int'(eo));
      chk("R10", int'(poe[i]), int'(ee));
    end
  endtask

  // one clock: model update at the edge, then quarter and three-quarter samples
  task automatic cycle();
    int s;
    bit sv;
    @(posedge clk);
    p_fm = c_fm; p_mfb = c_mfb; p_sig = c_sig;
    c_fm  = (m_pos == int'(fmp));
    c_mfb = f_mfb(m_pos, m_frame);
    c_sig = f_sig(m_pos, m_frame);
    s  = sync_src();
    sv = (s >= 0) ? pin[s] : 1'b0;
    if (sv) begin
      m_pos   = (int'(off) < flen()) ? int'(off) : 0;
      m_frame = 0;
    end else if (m_pos >= flen() - 1) begin
      m_pos   = 0;
      m_frame = (m_frame >= mflen() - 1) ? 0 : m_frame + 1;
    end else begin
      m_pos++;
    end
    #5;
    if (fall) cmp_ports(p_fm, p_mfb, p_sig, "R11");
    else      cmp_ports(c_fm, c_mfb, c_sig, "R11");
    #10;
    cmp_ports(c_fm, c_mfb, c_sig, "");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic pulse(int p);
    pin[p] = 1'b1;
    cycle();
    pin[p] = 1'b0;
  endtask

  // R4: spacing of frame-marker pulses on port 1
  task automatic measure(int exp);
    int n;
    n = 0;
    do begin cycle(); n++; end while (pout[1] !== 1'b1 && n < 400);
    n = 0;
    do begin cycle(); n++; end while (pout[1] !== 1'b1 && n < 400);
    chk("R4", n, exp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    func = 16'h3210;
    repeat (3) @(posedge clk);
    #15;
    chk("R1", int'(pout), 0);
    chk("R10", int'(poe), 4'b1110);
    rst_n = 1'b1;

    // E1, CRC multiframe marking
    off = 8'd5; fmp = 8'd10; mask = 32'hA5C3_0F81;
    pulse(0);
    run(2 * 16 * 256);
    measure(256);
    // E1, CAS multiframe marking
    cas = 1'b1;
    run(16 * 256 + 10);
    cas = 1'b0;
    // T1 12-frame multiframe
    t1 = 1'b1; mf_sel = 1'b1; off = 8'd0; fmp = 8'd100;
    pulse(0);
    run(2 * 12 * 193);
    measure(193);
    // T1 24-frame, multiframe marking then 12-frame marking
    esf = 1'b1;
    pulse(0);
    run(24 * 193);
    mf_sel = 1'b0;
    run(24 * 193);
    // robbed-bit signaling marks
    rbs = 1'b1;
    run(24 * 193 + 5);
    rbs = 1'b0;
    // R3: offset beyond the T1 frame, then a legal offset
    tag = "R3";
    off = 8'd200;
    pulse(0);
    run(400);
    off = 8'd7;
    pulse(0);
    run(400);
    tag = "";
    // R2: priority among sync-coded ports, output port pin ignored
    tag = "R2";
    func = 16'h2001;
    pulse(0);
    run(300);
    pulse(2);
    run(300);
    pulse(1);
    run(400);
    tag = "";
    // R10: undefined codes
    tag = "R10";
    func = 16'h0F35;
    run(300);
    tag = "";
    // R11: falling-edge launch, back in E1
    func = 16'h3210; t1 = 1'b0; esf = 1'b0;
    pulse(0);
    fall = 1'b1;
    run(2000);
    fall = 1'b0;
    run(50);

    summary();
    $finish;
  end
endmodule